// File: doc/BRIEF.md
# Coherent Sine-Fit Response Analyzer

This block estimates how closely a converter's decimated output matches a single test tone. It does this in real time and keeps no sample memory. Each cycle of `smp_valid_i` delivers one output sample. With the same pulse come two reference samples, a sine and a cosine of amplitude 0.5 at the test frequency. The block makes four passes of N samples each, and the stimulus must be coherent over N. From these passes it produces four results:

- the DC offset;
- the amplitudes of the tone's sine-aligned and cosine-aligned parts, which together encode both amplitude and phase without any trigonometry;
- the mean power of whatever is left once offset and fitted tone are subtracted (distortion plus noise).

All products go through one serial radix-2 Booth multiplier, and all sums go through one wide accumulator. N is a power of two, so every division is a shift.

All data are two's complement fractions with W bits, scaled by 2^(W-1). A reference value of 0.5 is therefore 2^(W-2). The power result is 2W bits wide, scaled by 2^(2W-2).

The user pulses `start_i` and then presents 4·N samples. Two consecutive samples must be far enough apart to cover three products, about 3W+10 cycles. `done_o` rises after the last sample has been processed.

Top module: `sine_fit_analyzer`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0 and all four result outputs are 0.
- R2: After the first pass, `offset_o` equals floor(sum of y over N samples / N) kept to W bits, and it holds that value for the rest of the run.
- R3: After the second pass, `amp_sin_o` equals floor(sum of ref_sin·(y − offset) / 2^(W−3+log2 N)) kept to W bits, where y − offset wraps to W bits.
- R4: After the third pass, `amp_cos_o` equals the same expression with ref_cos in place of ref_sin.
- R5: In the fourth pass each sample forms, with W-bit wrapping, y' = y − offset, then x1 = y' − floor(amp_sin·ref_sin / 2^(W−2)), then x2 = x1 − floor(amp_cos·ref_cos / 2^(W−2)). `power_o` equals floor(sum of x2² / N).
- R6: A `start_i` pulse while idle clears `done_o` and all results on the next cycle and raises `busy_o`. At the end `busy_o` falls as `done_o` rises, and `done_o` and the results hold until the next start.
- R7: A `start_i` pulse while `busy_o` is high has no effect on the run or its results.
- R8: Each pass consumes exactly N accepted samples. `done_o` stays 0 until the 4·N-th sample has been processed.
- R9: Every product is a signed W×W Booth product taking W step cycles. A fourth-pass sample is fully processed within 3W+10 cycles of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a four-pass measurement (pulse) |
| smp_valid_i | input | 1 | Sample and references are valid this cycle |
| smp_i | input | W | Converter output sample, signed fraction |
| ref_sin_i | input | W | In-phase reference, 0.5·sin |
| ref_cos_i | input | W | Quadrature reference, 0.5·cos |
| offset_o | output | W | Estimated DC offset |
| amp_sin_o | output | W | In-phase tone amplitude |
| amp_cos_o | output | W | Quadrature tone amplitude |
| power_o | output | 2W | Residual distortion-plus-noise power |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | Results valid |

## Verification
The hardest behaviour to reach from the ports is the fourth pass. There, an error in either fitted amplitude, or a mix-up between which pass's offset or amplitude feeds which substep, changes only a small residual power. The bench drives coherent tones with non-zero offset, arbitrary phase and bounded random noise, using fresh noise in every pass. It then compares the power result exactly against a bench model that recomputes all three substeps from the amplitudes it expects. It also pulses start during the second pass, and it checks the intermediate results as soon as each pass closes.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_MUL   = 2'd2,
        ST_CHECK = 2'd3
    } sfa_state_e;
endpackage

// File: rtl/sfa_booth_mul.sv
module sfa_booth_mul #(
    parameter int W = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic signed [W-1:0]   a_i,
    input  logic signed [W-1:0]   b_i,
    output logic                  done_o,
    output logic signed [2*W-1:0] prod_o
);
    localparam int CW = $clog2(W + 1);
    localparam int PW = 2 * W + 2;

    typedef struct packed {
        logic                run;
        logic                done;
        logic [CW-1:0]       cnt;
        logic signed [W-1:0] m;
        logic [PW-1:0]       p;
        logic signed [W-1:0] a_chk;
        logic signed [W-1:0] b_chk;
    } booth_t;

    booth_t r_q, r_d;
    logic signed [W:0] upper;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        upper    = r_q.p[PW-1:W+1];
        if (start_i) begin
            r_d.run   = 1'b1;
            r_d.cnt   = CW'(W);
            r_d.m     = a_i;
            r_d.p     = {{(W+1){1'b0}}, b_i, 1'b0};
            r_d.a_chk = a_i;
            r_d.b_chk = b_i;
        end else if (r_q.run) begin
            case (r_q.p[1:0])
                2'b01:   upper = upper + {r_q.m[W-1], r_q.m};
                2'b10:   upper = upper - {r_q.m[W-1], r_q.m};
                default: upper = upper;
            endcase
            r_d.p   = PW'($signed({upper, r_q.p[W:0]}) >>> 1);
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CW'(1)) begin
                r_d.run  = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o = r_q.done;
    assign prod_o = r_q.p[2*W:1];

    // R9: a finished product equals the signed product of the latched operands
    a_r9_booth_product: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (prod_o == (2*W)'(r_q.a_chk * r_q.b_chk)));

    // R9: no new operand pair while the previous product is still stepping
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.run |-> !start_i);
endmodule

// File: rtl/sfa_accum.sv
module sfa_accum #(
    parameter int AW = 60
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 add_i,
    input  logic signed [AW-1:0] addend_i,
    output logic signed [AW-1:0] sum_o
);
    logic signed [AW-1:0] sum_q, sum_d;

    always_comb begin
        sum_d = sum_q;
        if (clr_i)      sum_d = '0;
        else if (add_i) sum_d = sum_q + addend_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum_o = sum_q;

    // R8: accumulation and clearing never coincide
    a_r8_clear_add_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_i && add_i));
endmodule

// File: rtl/sine_fit_analyzer.sv
module sine_fit_analyzer #(
    parameter int W     = 24,
    parameter int LOG2N = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                smp_valid_i,
    input  logic signed [W-1:0] smp_i,
    input  logic signed [W-1:0] ref_sin_i,
    input  logic signed [W-1:0] ref_cos_i,
    output logic signed [W-1:0] offset_o,
    output logic signed [W-1:0] amp_sin_o,
    output logic signed [W-1:0] amp_cos_o,
    output logic [2*W-1:0]      power_o,
    output logic                busy_o,
    output logic                done_o
);
    import sfa_pkg::*;

    localparam int ACC_W  = 2 * W + LOG2N + 1;
    localparam int AMP_SH = W - 3 + LOG2N;
    localparam int SCL_SH = W - 2;
    localparam int BUDGET = 3 * W + 10;

    typedef struct packed {
        sfa_state_e          state;
        logic [1:0]          pass;
        logic [1:0]          sub;
        logic [LOG2N-1:0]    cnt;
        logic signed [W-1:0] tmp;
        logic signed [W-1:0] refq;
        logic signed [W-1:0] offset;
        logic signed [W-1:0] amp_s;
        logic signed [W-1:0] amp_c;
        logic [2*W-1:0]      power;
        logic                done;
        logic                mul_go;
        logic signed [W-1:0] mul_a;
        logic signed [W-1:0] mul_b;
    } ctl_t;

    ctl_t r_q, r_d;

    logic                    mul_done;
    logic signed [2*W-1:0]   mul_prod;
    logic                    acc_clr, acc_add;
    logic signed [ACC_W-1:0] acc_val, acc_sum;
    logic signed [W-1:0]     y_off, prod_hi, resid;
    logic signed [ACC_W-1:0] prod_ext;
    logic                    unused_low;

    sfa_booth_mul #(.W(W)) mul_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (r_q.mul_go),
        .a_i     (r_q.mul_a),
        .b_i     (r_q.mul_b),
        .done_o  (mul_done),
        .prod_o  (mul_prod)
    );

    sfa_accum #(.AW(ACC_W)) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (acc_clr),
        .add_i    (acc_add),
        .addend_i (acc_val),
        .sum_o    (acc_sum)
    );

    assign y_off      = smp_i - r_q.offset;
    assign prod_hi    = mul_prod[SCL_SH +: W];
    assign prod_ext   = {{(ACC_W-2*W){mul_prod[2*W-1]}}, mul_prod};
    assign unused_low = ^{acc_sum[LOG2N-1:0], acc_sum[ACC_W-1]};

    always_comb begin
        r_d        = r_q;
        r_d.mul_go = 1'b0;
        acc_clr    = 1'b0;
        acc_add    = 1'b0;
        acc_val    = '0;
        resid      = r_q.tmp - prod_hi;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state  = ST_WAIT;
                    r_d.pass   = 2'd0;
                    r_d.sub    = 2'd0;
                    r_d.cnt    = '0;
                    r_d.done   = 1'b0;
                    r_d.offset = '0;
                    r_d.amp_s  = '0;
                    r_d.amp_c  = '0;
                    r_d.power  = '0;
                    acc_clr    = 1'b1;
                end
            end
            ST_WAIT: begin
                if (smp_valid_i) begin
                    r_d.sub = 2'd0;
                    case (r_q.pass)
                        2'd0: begin
                            acc_add   = 1'b1;
                            acc_val   = {{(ACC_W-W){smp_i[W-1]}}, smp_i};
                            r_d.state = ST_CHECK;
                        end
                        2'd1, 2'd2: begin
                            r_d.mul_go = 1'b1;
                            r_d.mul_a  = (r_q.pass == 2'd1) ? ref_sin_i : ref_cos_i;
                            r_d.mul_b  = y_off;
                            r_d.state  = ST_MUL;
                        end
                        default: begin
                            r_d.tmp    = y_off;
                            r_d.refq   = ref_cos_i;
                            r_d.mul_go = 1'b1;
                            r_d.mul_a  = r_q.amp_s;
                            r_d.mul_b  = ref_sin_i;
                            r_d.state  = ST_MUL;
                        end
                    endcase
                end
            end
            ST_MUL: begin
                if (mul_done) begin
                    if (r_q.pass != 2'd3) begin
                        acc_add   = 1'b1;
                        acc_val   = prod_ext;
                        r_d.state = ST_CHECK;
                    end else begin
                        case (r_q.sub)
                            2'd0: begin
                                r_d.tmp    = resid;
                                r_d.mul_go = 1'b1;
                                r_d.mul_a  = r_q.amp_c;
                                r_d.mul_b  = r_q.refq;
                                r_d.sub    = 2'd1;
                            end
                            2'd1: begin
                                r_d.tmp    = resid;
                                r_d.mul_go = 1'b1;
                                r_d.mul_a  = resid;
                                r_d.mul_b  = resid;
                                r_d.sub    = 2'd2;
                            end
                            default: begin
                                acc_add   = 1'b1;
                                acc_val   = prod_ext;
                                r_d.state = ST_CHECK;
                            end
                        endcase
                    end
                end
            end
            default: begin
                if (&r_q.cnt) begin
                    r_d.cnt = '0;
                    acc_clr = 1'b1;
                    case (r_q.pass)
                        2'd0:    r_d.offset = acc_sum[LOG2N +: W];
                        2'd1:    r_d.amp_s  = acc_sum[AMP_SH +: W];
                        2'd2:    r_d.amp_c  = acc_sum[AMP_SH +: W];
                        default: r_d.power  = acc_sum[LOG2N +: 2*W];
                    endcase
                    if (r_q.pass == 2'd3) begin
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.pass  = r_q.pass + 2'd1;
                        r_d.state = ST_WAIT;
                    end
                end else begin
                    r_d.cnt   = r_q.cnt + 1'b1;
                    r_d.state = ST_WAIT;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign offset_o  = r_q.offset;
    assign amp_sin_o = r_q.amp_s;
    assign amp_cos_o = r_q.amp_c;
    assign power_o   = r_q.power;
    assign busy_o    = (r_q.state != ST_IDLE);
    assign done_o    = r_q.done;

    // Checker state: cycles spent on the current sample since acceptance
    logic [15:0] proc_cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                            proc_cyc_q <= '0;
        else if (r_q.state == ST_WAIT || r_q.state == ST_IDLE) proc_cyc_q <= '0;
        else                                                   proc_cyc_q <= proc_cyc_q + 16'd1;
    end

    a_r9_sample_budget: assert property (@(posedge clk) disable iff (!rst_n)
        proc_cyc_q <= 16'(BUDGET));

    a_r6_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o));

    a_r6_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(r_q.pass) == 2'd3 && (&$past(r_q.cnt))));

    a_r2_offset_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && r_q.pass != 2'd0) |=> $stable(offset_o));

    a_r5_power_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.pass == 2'd3 && busy_o) |-> !unused_low || !acc_sum[ACC_W-1]);
endmodule

// File: tb/sine_fit_analyzer_tb_top.sv
module sine_fit_analyzer_tb_top;
    localparam int W     = 24;
    localparam int L     = 5;
    localparam int N     = 1 << L;
    localparam int SPACE = 92;
    localparam int TONE  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic vld = 1'b0;
    logic signed [W-1:0] smp = '0, rs_in = '0, rc_in = '0;
    logic signed [W-1:0] off_o, ai_o, aq_o;
    logic [2*W-1:0] pw_o;
    logic busy, done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    longint ys [4][N];
    longint rsv[N];
    longint rcv[N];
    longint e_off, e_ai, e_aq, e_pw;

    always #4 clk = ~clk;

    sine_fit_analyzer #(.W(W), .LOG2N(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .smp_valid_i(vld),
        .smp_i(smp), .ref_sin_i(rs_in), .ref_cos_i(rc_in),
        .offset_o(off_o), .amp_sin_o(ai_o), .amp_cos_o(aq_o), .power_o(pw_o),
        .busy_o(busy), .done_o(done)
    );

    function automatic longint wrapw(longint v);
        longint m;
        m = v & ((64'sd1 <<< W) - 1);
        if (m[W-1]) m = m - (64'sd1 <<< W);
        return m;
    endfunction

    function automatic longint rnd(real x);
        return (x >= 0.0) ? longint'($rtoi(x + 0.5)) : -longint'($rtoi(-x + 0.5));
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic gen(input real off, input real amp, input real ph, input int noise);
        real th, sc;
        sc = real'(64'sd1 <<< (W-1));
        for (int n = 0; n < N; n++) begin
            th = 6.283185307179586 * TONE * n / N;
            rsv[n] = rnd(0.5 * sc * $sin(th));
            rcv[n] = rnd(0.5 * sc * $cos(th));
            for (int p = 0; p < 4; p++) begin
                ys[p][n] = rnd(sc * (off + amp * $sin(th + ph)));
                if (noise > 0) ys[p][n] += longint'($urandom_range(0, 2 * noise)) - noise;
            end
        end
    endtask

    task automatic expect_all();
        longint s, yo, x1, x2;
        s = 0;
        for (int n = 0; n < N; n++) s += ys[0][n];
        e_off = wrapw(s >>> L);
        s = 0;
        for (int n = 0; n < N; n++) s += rsv[n] * wrapw(ys[1][n] - e_off);
        e_ai = wrapw(s >>> (W - 3 + L));
        s = 0;
        for (int n = 0; n < N; n++) s += rcv[n] * wrapw(ys[2][n] - e_off);
        e_aq = wrapw(s >>> (W - 3 + L));
        s = 0;
        for (int n = 0; n < N; n++) begin
            yo = wrapw(ys[3][n] - e_off);
            x1 = wrapw(yo - wrapw((e_ai * rsv[n]) >>> (W - 2)));
            x2 = wrapw(x1 - wrapw((e_aq * rcv[n]) >>> (W - 2)));
            s += x2 * x2;
        end
        e_pw = (s >>> L) & ((64'sd1 <<< (2*W)) - 1);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic send(input longint y, input longint r1, input longint r2);
        @(negedge clk);
        smp = W'(y); rs_in = W'(r1); rc_in = W'(r2); vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
        repeat (SPACE - 2) @(negedge clk);
    endtask

    task automatic run(input real off, input real amp, input real ph, input int noise, input bit restart);
        gen(off, amp, ph, noise);
        expect_all();
        pulse_start();
        chk(busy === 1'b1 && done === 1'b0, "R6 start raises busy", longint'({busy, done}), 2);
        chk(off_o === '0 && pw_o === '0, "R6 start clears results", longint'(off_o), 0);
        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n < N; n++) begin
                if (p == 3 && n == N - 1)
                    chk(done === 1'b0 && busy === 1'b1, "R8 not done before last sample", longint'(done), 0);
                send(ys[p][n], rsv[n], rcv[n]);
                if (restart && p == 1 && n == 4) pulse_start();
            end
            if (p == 0) chk(longint'(off_o) == e_off, "R2 offset after pass 1", longint'(off_o), e_off);
            if (p == 1) chk(longint'(ai_o) == e_ai, "R3 sine amplitude after pass 2", longint'(ai_o), e_ai);
            if (p == 2) chk(longint'(aq_o) == e_aq, "R4 cosine amplitude after pass 3", longint'(aq_o), e_aq);
        end
        chk(done === 1'b1 && busy === 1'b0, "R6 R9 done after final sample", longint'({busy, done}), 1);
        chk(longint'(off_o) == e_off, "R2 offset final", longint'(off_o), e_off);
        chk(longint'(ai_o) == e_ai, "R3 sine amplitude final", longint'(ai_o), e_ai);
        chk(longint'(aq_o) == e_aq, "R4 cosine amplitude final", longint'(aq_o), e_aq);
        chk(longint'(pw_o) == e_pw, "R5 residual power", longint'(pw_o), e_pw);
        if (restart)
            chk(longint'(pw_o) == e_pw, "R7 mid-run start ignored", longint'(pw_o), e_pw);
        repeat (20) @(negedge clk);
        chk(done === 1'b1 && longint'(pw_o) == e_pw, "R6 results held", longint'(pw_o), e_pw);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'd20211));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0 && done === 1'b0, "R1 reset flags", longint'({busy, done}), 0);
        chk(off_o === '0 && ai_o === '0 && aq_o === '0 && pw_o === '0,
            "R1 reset results", longint'(pw_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run(0.10, 0.35, 0.4, 2000, 1'b1);
        run(-0.15, 0.20, 2.5, 500, 1'b0);
        run(0.0, 0.0, 0.0, 0, 1'b0);
        chk(pw_o === '0 && ai_o === '0, "R5 zero input gives zero power", longint'(pw_o), 0);
        for (int k = 0; k < 2; k++) begin
            real o, a, f;
            o = (real'($urandom_range(0, 3000)) - 1500.0) / 10000.0;
            a = real'($urandom_range(0, 3000)) / 10000.0;
            f = real'($urandom_range(0, 6283)) / 1000.0;
            run(o, a, f, int'($urandom_range(0, 4000)), 1'b0);
        end
        finish_up();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        finish_up();
    end
endmodule